// File: doc/BRIEF.md
# Serial Character Transmitter with Break Control

This block turns parallel bytes into asynchronous serial frames on a single line. The system writes a byte into a one-entry holding register, and the shifter takes it from there. Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop period that is one, one and a half or two bit times long. All timing comes from an oversampling tick input; each bit lasts `OVS` ticks. A baud generator supplies the tick and a register front end supplies the mode fields and command pulses; neither is part of this block.

Two flow-control options are available. When automatic clear-to-send gating is on, a character waits in the holding register until `cts` is high. When request-to-send tracking is on, `rts` is high exactly while a character is held or being shifted. A break command forces the line low once any character already on the line has finished. After the break is released, the line stays high for at least one bit time before the next start bit. Enable, disable and transmitter-reset pulses control whether bytes are accepted. Two status outputs report whether the holding register is free and whether the transmitter has gone idle.

Top module: `uart_tx_core`

## Requirements
- R1: After `rst_n` is released, `txd` is 1, `tx_ready` is 0 (the transmitter starts disabled), `tx_empty` is 1 and `rts` is 0.
- R2: A frame is a 0 start bit followed by the data bits, least significant first. `len_sel` 0, 1, 2, 3 selects 5, 6, 7, 8 data bits, and data bits above the selected length are not sent. Every start, data and parity bit lasts `OVS` ticks.
- R3: `par_sel` selects the parity bit. Any code with bit 2 set means no parity bit. 3'b000 gives even parity over the sent data bits, 3'b001 gives odd parity, 3'b010 sends a constant 0 and 3'b011 sends a constant 1.
- R4: `stop_sel` 4'hF gives a 2*OVS-tick stop period, 4'h8 gives 1.5*OVS ticks, and every other value gives OVS ticks. `tx_empty` rises on the tick that ends the stop period when nothing is held.
- R5: `tx_ready` is high only while the transmitter is enabled and the holding register is free. A `wr_stb` while `tx_ready` is low is ignored.
- R6: A byte written while another is being shifted is sent right after it, with no extra idle bit time.
- R7: `tx_empty` goes low on the cycle after an accepted write and stays low until the last stop period ends with nothing held.
- R8: With `cts_auto` set, a held character does not start while `cts` is low, and it starts once `cts` goes high.
- R9: With `rts_auto` set, `rts` equals the inverse of `tx_empty`. With `rts_auto` clear, `rts` stays 0.
- R10: `brk_start` drives `txd` low two cycles later when the line is idle, or right after the stop period of a character in flight. `brk_stop` releases the line, and at least OVS ticks of high line follow before any start bit.
- R11: A `tx_rst` pulse discards the held byte, aborts the current character, cancels any break and disables the transmitter. On the next cycle `txd` is 1, `tx_empty` is 1 and `tx_ready` is 0.
- R12: `tx_dis` stops writes from being accepted but lets held and in-flight characters finish; `tx_en` re-enables acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling tick, one cycle wide |
| wr_data | input | 8 | Byte to transmit |
| wr_stb | input | 1 | Write strobe for `wr_data` |
| len_sel | input | 2 | Data length code (5 + value bits) |
| par_sel | input | 3 | Parity mode code |
| stop_sel | input | 4 | Stop length code |
| cts_auto | input | 1 | Hold off new characters while `cts` is low |
| rts_auto | input | 1 | Drive `rts` while the transmitter is busy |
| cts | input | 1 | Clear-to-send, active high |
| tx_en | input | 1 | Enable pulse |
| tx_dis | input | 1 | Disable pulse |
| tx_rst | input | 1 | Transmitter reset pulse |
| brk_start | input | 1 | Begin break pulse |
| brk_stop | input | 1 | End break pulse |
| txd | output | 1 | Serial line, idle high |
| rts | output | 1 | Request-to-send, active high |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_empty | output | 1 | Nothing held and nothing shifting |

## Verification
The bench builds the block with the default `OVS` of 16 and drives a tick every second clock. This makes 24-tick and 32-tick stop periods measurable to the exact tick, with one clock of slack at each tick. With that ratio, a 12-bit frame takes about 400 clocks, so every length code, every parity code and all three stop lengths fit in one short run. The same run also covers back-to-back characters, clear-to-send hold-off and a break that arrives in the middle of a character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_BRK   = 3'd5,
    ST_GAP   = 3'd6
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic [2:0] par;
    logic [3:0] stop;
  } tx_cfg_t;

  // number of data bits for a length code
  function automatic int unsigned char_bits(logic [1:0] len);
    return 32'd5 + 32'(len);
  endfunction

  // clear the bits beyond the selected length
  function automatic logic [DATA_W-1:0] keep_bits(logic [DATA_W-1:0] d, logic [1:0] len);
    return d & (8'hFF >> (2'd3 - len));
  endfunction

  function automatic logic parity_of(logic [2:0] mode, logic [DATA_W-1:0] kept);
    logic p;
    unique case (mode[1:0])
      2'b00:   p = ^kept;
      2'b01:   p = ~^kept;
      2'b10:   p = 1'b0;
      default: p = 1'b1;
    endcase
    return p;
  endfunction

  // stop period in ticks
  function automatic int unsigned stop_ticks(logic [3:0] sel, int unsigned ovs);
    int unsigned n;
    if (sel == 4'hF)      n = 2 * ovs;
    else if (sel == 4'h8) n = ovs + ovs / 2;
    else                  n = ovs;
    return n;
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              en_pulse,
  input  logic              dis_pulse,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output logic              ready
);

  logic enabled;
  logic accept;

  assign ready  = enabled && !hold_valid;
  assign accept = wr_stb && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled    <= 1'b0;
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (soft_rst) begin
      enabled    <= 1'b0;
      hold_valid <= 1'b0;
    end else begin
      if (dis_pulse)     enabled <= 1'b0;
      else if (en_pulse) enabled <= 1'b1;
      if (accept) begin
        hold_valid <= 1'b1;
        hold_data  <= wr_data;
      end else if (take) begin
        hold_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic brk_start,
  input  logic brk_stop,
  output logic brk_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   brk_req <= 1'b0;
    else if (soft_rst || brk_stop) brk_req <= 1'b0;
    else if (brk_start)           brk_req <= 1'b1;
  end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tick,
  input  tx_cfg_t           cfg,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              cts_ok,
  input  logic              brk_req,
  output logic              take,
  output logic              txd,
  output logic              char_busy,
  output tx_state_e         state
);

  localparam int unsigned CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);

  logic [CW-1:0]     tcnt;
  logic [CW-1:0]     stop_last;
  logic [CW-1:0]     seg_lim;
  logic [2:0]        bidx;
  logic [2:0]        bit_last;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              par_on;
  logic              seg_end;

  assign take    = (state == ST_IDLE) && !brk_req && hold_valid && cts_ok && !soft_rst;
  assign seg_lim = (state == ST_STOP) ? stop_last : BIT_LAST;
  assign seg_end = tick && (tcnt == seg_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      bit_last  <= '0;
      stop_last <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      par_on    <= 1'b0;
    end else if (soft_rst) begin
      state <= ST_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
    end else begin
      if (tick && state != ST_IDLE && state != ST_BRK)
        tcnt <= seg_end ? '0 : tcnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          tcnt <= '0;
          if (brk_req) begin
            state <= ST_BRK;
          end else if (take) begin
            state     <= ST_START;
            shreg     <= keep_bits(hold_data, cfg.len);
            pbit      <= parity_of(cfg.par, keep_bits(hold_data, cfg.len));
            par_on    <= !cfg.par[2];
            bit_last  <= 3'(char_bits(cfg.len) - 1);
            stop_last <= CW'(stop_ticks(cfg.stop, OVS) - 1);
          end
        end
        ST_START: if (seg_end) begin
          state <= ST_DATA;
          bidx  <= '0;
        end
        ST_DATA: if (seg_end) begin
          shreg <= shreg >> 1;
          if (bidx == bit_last) state <= par_on ? ST_PAR : ST_STOP;
          else                  bidx  <= bidx + 1'b1;
        end
        ST_PAR:  if (seg_end) state <= ST_STOP;
        ST_STOP: if (seg_end) state <= ST_IDLE;
        ST_BRK: begin
          tcnt <= '0;
          if (!brk_req) state <= ST_GAP;
        end
        ST_GAP:  if (seg_end) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = pbit;
      ST_BRK:   txd = 1'b0;
      default:  txd = 1'b1;
    endcase
  end

  assign char_busy = (state == ST_START) || (state == ST_DATA) ||
                     (state == ST_PAR)   || (state == ST_STOP);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] wr_data,
  input  logic       wr_stb,
  input  logic [1:0] len_sel,
  input  logic [2:0] par_sel,
  input  logic [3:0] stop_sel,
  input  logic       cts_auto,
  input  logic       rts_auto,
  input  logic       cts,
  input  logic       tx_en,
  input  logic       tx_dis,
  input  logic       tx_rst,
  input  logic       brk_start,
  input  logic       brk_stop,
  output logic       txd,
  output logic       rts,
  output logic       tx_ready,
  output logic       tx_empty
);

  tx_cfg_t           cfg;
  tx_state_e         st;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              brk_req;
  logic              char_busy;
  logic              cts_ok;

  assign cfg    = '{len: len_sel, par: par_sel, stop: stop_sel};
  assign cts_ok = !cts_auto || cts;

  uart_tx_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (tx_rst),
    .en_pulse   (tx_en),
    .dis_pulse  (tx_dis),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .take       (take),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .ready      (tx_ready)
  );

  uart_tx_brk u_brk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (tx_rst),
    .brk_start (brk_start),
    .brk_stop  (brk_stop),
    .brk_req   (brk_req)
  );

  uart_tx_shift #(.OVS(OVS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (tx_rst),
    .tick       (tick),
    .cfg        (cfg),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .cts_ok     (cts_ok),
    .brk_req    (brk_req),
    .take       (take),
    .txd        (txd),
    .char_busy  (char_busy),
    .state      (st)
  );

  assign tx_empty = !hold_valid && !char_busy;
  assign rts      = rts_auto && !tx_empty;

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk
  import uart_tx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_stb,
  input logic              tx_ready,
  input logic              tx_empty,
  input logic              txd,
  input logic              tx_rst,
  input logic              cts_auto,
  input logic              cts,
  input logic              brk_req,
  input tx_state_e         st,
  input logic [DATA_W-1:0] hold_data
);

  // R5
  refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !tx_ready && !tx_rst) |=> $stable(hold_data));

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_ready && !tx_rst) |=> !tx_empty);

  // R8
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && $past(st) == ST_IDLE && $past(cts_auto)) |-> $past(cts));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> (txd && tx_empty && !tx_ready));

  // R10
  break_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(brk_req) && st == ST_IDLE && !tx_rst) |=> !txd);

  // R2
  seg_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != st && !$past(tx_rst) &&
     ($past(st) == ST_START || $past(st) == ST_DATA || $past(st) == ST_PAR ||
      $past(st) == ST_STOP  || $past(st) == ST_GAP)) |-> $past(tick));

endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_stb    (wr_stb),
  .tx_ready  (tx_ready),
  .tx_empty  (tx_empty),
  .txd       (txd),
  .tx_rst    (tx_rst),
  .cts_auto  (cts_auto),
  .cts       (cts),
  .brk_req   (brk_req),
  .st        (st),
  .hold_data (hold_data)
);

// File: tb/sim_uart_tx_core.sv
module sim_uart_tx_core;

  localparam int CLK_PERIOD = 10;
  localparam int BT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_stb = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic [2:0] par_sel = 3'b100;
  logic [3:0] stop_sel = 4'h7;
  logic       cts_auto = 1'b0;
  logic       rts_auto = 1'b0;
  logic       cts = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_dis = 1'b0;
  logic       tx_rst = 1'b0;
  logic       brk_start = 1'b0;
  logic       brk_stop = 1'b0;
  logic       txd, rts, tx_ready, tx_empty;

  int nchecks = 0;
  int nfail = 0;
  int tick_seen = 0;
  int cycles = 0;
  int last_t0 = 0;

  uart_tx_core #(.OVS(BT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_data(wr_data), .wr_stb(wr_stb),
    .len_sel(len_sel), .par_sel(par_sel), .stop_sel(stop_sel),
    .cts_auto(cts_auto), .rts_auto(rts_auto), .cts(cts),
    .tx_en(tx_en), .tx_dis(tx_dis), .tx_rst(tx_rst),
    .brk_start(brk_start), .brk_stop(brk_stop),
    .txd(txd), .rts(rts), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // tick on every second clock; tick_seen counts ticks the design has sampled
  always @(posedge clk) begin
    tick <= rst_n ? ~tick : 1'b0;
    if (tick) tick_seen <= tick_seen + 1;
    cycles <= cycles + 1;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      nchecks = nchecks + 1;
      nfail = nfail + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nchecks = nchecks + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(input logic [7:0] v, input int nb);
    int c = 0;
    for (int i = 0; i < nb; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic int exp_stop(input logic [3:0] s);
    if (s == 4'hF) return 2 * BT;
    if (s == 4'h8) return BT + BT / 2;
    return BT;
  endfunction

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_tk(input int t0, input int n);
    while (tick_seen - t0 < n) @(negedge clk);
  endtask

  task automatic capture(input int nb, input bit pe, output logic [7:0] d,
                         output logic pb, output logic framed);
    int t0;
    int idx;
    logic sb;
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_seen;
    last_t0 = t0;
    d = '0;
    pb = 1'b0;
    wait_tk(t0, BT / 2);
    sb = txd;
    for (int i = 0; i < nb; i++) begin
      wait_tk(t0, BT * (i + 1) + BT / 2);
      d[i] = txd;
    end
    idx = nb + 1;
    if (pe) begin
      wait_tk(t0, BT * idx + BT / 2);
      pb = txd;
      idx++;
    end
    wait_tk(t0, BT * idx + BT / 2);
    framed = (sb == 1'b0) && (txd == 1'b1);
  endtask

  task automatic wait_empty(output int elapsed);
    while (tx_empty !== 1'b1) @(negedge clk);
    elapsed = tick_seen - last_t0;
  endtask

  task automatic frame_test(input string req, input logic [7:0] d, input logic [1:0] len,
                            input logic [2:0] par, input logic [3:0] stp);
    logic [7:0] got;
    logic pb, fr;
    int el, nb, pe, expp;
    nb = 5 + int'(len);
    pe = par[2] ? 0 : 1;
    len_sel = len; par_sel = par; stop_sel = stp;
    send(d);
    capture(nb, pe[0], got, pb, fr);
    check(req, "data bits", int'(got), int'(d & 8'((1 << nb) - 1)));
    check(req, "start/stop levels", int'(fr), 1);
    if (pe == 1) begin
      case (par[1:0])
        2'b00: expp = ones(d, nb) % 2;
        2'b01: expp = 1 - (ones(d, nb) % 2);
        2'b10: expp = 0;
        default: expp = 1;
      endcase
      check("R3", "parity bit", int'(pb), expp);
    end
    wait_empty(el);
    check("R4", "frame ticks to empty", el, BT * (1 + nb + pe) + exp_stop(stp));
  endtask

  task automatic t_reset();
    check("R1", "txd idle", int'(txd), 1);
    check("R1", "tx_ready", int'(tx_ready), 0);
    check("R1", "tx_empty", int'(tx_empty), 1);
    check("R1", "rts", int'(rts), 0);
  endtask

  task automatic t_enable();
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk); tx_en = 1'b0;
    check("R12", "ready after enable", int'(tx_ready), 1);
  endtask

  task automatic t_b2b();
    logic [7:0] got;
    logic pb, fr;
    len_sel = 2'd3; par_sel = 3'b100; stop_sel = 4'h7;
    send(8'h3A);
    while (tx_ready !== 1'b1) @(negedge clk);
    send(8'hC5);
    check("R5", "ready low while held", int'(tx_ready), 0);
    send(8'h77);
    capture(8, 1'b0, got, pb, fr);
    check("R6", "first byte", int'(got), 8'h3A);
    capture(8, 1'b0, got, pb, fr);
    check("R6", "second byte back to back", int'(got), 8'hC5);
    check("R6", "second frame levels", int'(fr), 1);
    while (tx_empty !== 1'b1) @(negedge clk);
    repeat (200) begin
      @(negedge clk);
      if (txd !== 1'b1) break;
    end
    check("R5", "refused byte not sent", int'(txd), 1);
    check("R7", "empty after both frames", int'(tx_empty), 1);
  endtask

  task automatic t_cts();
    logic [7:0] got;
    logic pb, fr;
    int low_seen = 0;
    cts_auto = 1'b1; cts = 1'b0;
    send(8'h5C);
    repeat (300) begin
      @(negedge clk);
      if (txd !== 1'b1) low_seen = 1;
    end
    check("R8", "no start while cts low", low_seen, 0);
    check("R7", "not empty while held", int'(tx_empty), 0);
    cts = 1'b1;
    capture(8, 1'b0, got, pb, fr);
    check("R8", "byte after cts", int'(got), 8'h5C);
    while (tx_empty !== 1'b1) @(negedge clk);
    cts_auto = 1'b0;
  endtask

  task automatic t_rts();
    logic [7:0] got;
    logic pb, fr;
    check("R9", "rts low when mode off and idle", int'(rts), 0);
    rts_auto = 1'b1;
    @(negedge clk);
    check("R9", "rts low when idle", int'(rts), 0);
    send(8'h81);
    check("R9", "rts high after write", int'(rts), 1);
    capture(8, 1'b0, got, pb, fr);
    check("R9", "rts high in stop", int'(rts), 1);
    while (tx_empty !== 1'b1) @(negedge clk);
    check("R9", "rts released at empty", int'(rts), 0);
    rts_auto = 1'b0;
  endtask

  task automatic t_brk_idle();
    logic [7:0] got;
    logic pb, fr;
    int t_rel;
    @(negedge clk); brk_start = 1'b1;
    @(negedge clk); brk_start = 1'b0;
    @(negedge clk);
    check("R10", "line low on idle break", int'(txd), 0);
    send(8'h69);
    repeat (200) @(negedge clk);
    check("R10", "break holds over held byte", int'(txd), 0);
    brk_stop = 1'b1;
    @(negedge clk); brk_stop = 1'b0;
    while (txd !== 1'b1) @(negedge clk);
    t_rel = tick_seen;
    capture(8, 1'b0, got, pb, fr);
    check("R10", "gap at least one bit", int'((last_t0 - t_rel) >= BT), 1);
    check("R10", "byte after break", int'(got), 8'h69);
    while (tx_empty !== 1'b1) @(negedge clk);
  endtask

  task automatic t_brk_mid();
    logic [7:0] got;
    logic pb, fr;
    send(8'h96);
    fork
      capture(8, 1'b0, got, pb, fr);
      begin
        repeat (100) @(negedge clk);
        brk_start = 1'b1;
        @(negedge clk);
        brk_start = 1'b0;
      end
    join
    check("R10", "frame intact under break", int'(got), 8'h96);
    check("R10", "stop high under break", int'(fr), 1);
    while (tx_empty !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R10", "break after character", int'(txd), 0);
    brk_stop = 1'b1;
    @(negedge clk); brk_stop = 1'b0;
    repeat (2) @(negedge clk);
    check("R10", "line released", int'(txd), 1);
    repeat (4 * BT) @(negedge clk);
  endtask

  task automatic t_rst();
    int low_seen = 0;
    send(8'h00);
    repeat (60) @(negedge clk);
    tx_rst = 1'b1;
    @(negedge clk); tx_rst = 1'b0;
    check("R11", "txd high after reset", int'(txd), 1);
    check("R11", "empty after reset", int'(tx_empty), 1);
    check("R11", "disabled after reset", int'(tx_ready), 0);
    send(8'h00);
    repeat (200) begin
      @(negedge clk);
      if (txd !== 1'b1) low_seen = 1;
    end
    check("R11", "write ignored while disabled", low_seen, 0);
  endtask

  task automatic t_dis();
    logic [7:0] got;
    logic pb, fr;
    int low_seen = 0;
    t_enable();
    send(8'hE7);
    @(negedge clk); tx_dis = 1'b1;
    @(negedge clk); tx_dis = 1'b0;
    check("R12", "ready low after disable", int'(tx_ready), 0);
    capture(8, 1'b0, got, pb, fr);
    check("R12", "in-flight byte finishes", int'(got), 8'hE7);
    while (tx_empty !== 1'b1) @(negedge clk);
    send(8'h00);
    repeat (200) begin
      @(negedge clk);
      if (txd !== 1'b1) low_seen = 1;
    end
    check("R12", "write ignored when disabled", low_seen, 0);
    t_enable();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    frame_test("R2", 8'hA5, 2'd3, 3'b100, 4'h7);
    frame_test("R2", 8'h35, 2'd2, 3'b000, 4'h8);
    frame_test("R2", 8'hE3, 2'd0, 3'b001, 4'hF);
    frame_test("R3", 8'h2A, 2'd1, 3'b010, 4'h7);
    frame_test("R3", 8'h15, 2'd1, 3'b011, 4'h3);
    frame_test("R3", 8'h5B, 2'd3, 3'b000, 4'hF);
    t_b2b();
    t_cts();
    t_rts();
    t_brk_idle();
    t_brk_mid();
    t_rst();
    t_dis();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule